// File: doc/BRIEF.md
# Posit word decoder

This block unpacks one posit word into the parts that an arithmetic datapath works on. The bits after the sign begin with a run of identical bits. The length of that run sets a coarse scale. The bits that follow the run hold a short exponent and then a fraction. Because the run has no fixed length, the exponent and the fraction move inside the word. Either of them can be cut short or missing. Missing bits are read as zeros.

The block is purely combinational. A word on the input produces these outputs:
- a sign flag;
- flags for the zero word and for the not-a-real word;
- a signed combined scale, equal to the run-derived value times 2^ES plus the exponent;
- a significand with the hidden one at its top bit and the fraction left-aligned below it.

A negative word is decoded from its two's complement. The sign output still shows the original sign. Rounding, encoding and arithmetic are left to the blocks that use this one.

Top module: `posit_decoder`

## Requirements
- R1: The all-zero word sets is_zero_o=1 and is_nar_o=0, and drives neg_o=0, scale_o=0 and signif_o=0.
- R2: The word with only its top bit set (0x8000 for N=16) sets is_nar_o=1 and is_zero_o=0, and drives neg_o=0, scale_o=0 and signif_o=0.
- R3: For any other word, neg_o equals the word's top bit. The remaining outputs are those of the two's complement of the word: 0xC000 gives neg_o=1, scale 0 and significand 0x800, and 0x8001 gives neg_o=1, scale 56 and significand 0x800.
- R4: A leading run of k ones gives a run value of k-1, and a leading run of k zeros gives -k. The scale is that value times 4 plus the exponent, with ES=2. So 0x4000 gives scale 0, 0x3800 gives -1, 0x7FFF gives 56 and 0x0001 gives -56.
- R5: If only one exponent bit remains after the run and its terminating bit, that bit is the upper exponent bit and the lower bit is 0. If no exponent bits remain, the exponent is 0. So 0x0003 gives scale -50, 0x0002 gives -52 and 0x5000 gives 2.
- R6: For a non-special word, signif_o has its top bit (bit 11 for N=16) at 1. Below it, the remaining fraction bits sit left-aligned and the unused low bits are filled with zeros. So 0x4001 gives 0x801 and 0x4400 gives 0xC00.
- R7: For N=16, every one of the 65536 words decodes to the values that a bit-by-bit walk of the word, following R1 to R6, predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pw_i | input | N | Posit word to decode |
| neg_o | output | 1 | Sign of the value, 0 for the zero and not-a-real words |
| is_zero_o | output | 1 | Word is the zero pattern |
| is_nar_o | output | 1 | Word is the not-a-real pattern |
| scale_o | output | SW | Signed combined scale, run value times 2^ES plus exponent |
| signif_o | output | N-2-ES | Hidden bit followed by the left-aligned fraction |

## Verification
Two functions meet on the same word: the run-length count and the truncation of the exponent and fraction fields. The longer the run, the more of the following fields it pushes off the end of the word. The sharpest case is a run that leaves exactly one exponent bit, such as 0x0003. Here the count must be right, and the single remaining bit must land in the upper exponent position with a zero filled in below it. The exhaustive sweep reaches every run length together with every truncation of the fields, for both signs. A bit-by-bit reference walk in the bench judges each word against the expected sign, scale and significand.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    function automatic int scale_width(int n, int es);
        return $clog2(n << es) + 2;
    endfunction

    function automatic int frac_width(int n, int es);
        return n - 3 - es;
    endfunction

endpackage

// File: rtl/posit_abs.sv
module posit_abs #(
    parameter int N = 16
) (
    input  logic [N-1:0] word_i,
    output logic [N-2:0] body_o
);
    logic [N-2:0] low;

    always_comb begin
        low = word_i[N-2:0];
        if (word_i[N-1]) begin
            body_o = ~low + 1'b1;
        end else begin
            body_o = low;
        end
    end
endmodule

// File: rtl/posit_run_count.sv
module posit_run_count #(
    parameter int W  = 15,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic          lead_o,
    output logic [CW-1:0] run_o
);
    logic [W-1:0] flipped;

    always_comb begin
        lead_o  = bits_i[W-1];
        flipped = lead_o ? ~bits_i : bits_i;
        run_o   = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (flipped[i]) begin
                run_o = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/posit_field_align.sv
module posit_field_align #(
    parameter int ES = 2,
    parameter int FW = 11,
    parameter int CW = 4
) (
    input  logic [ES+FW-1:0] tail_i,
    input  logic [CW-1:0]    run_i,
    output logic [ES-1:0]    exp_o,
    output logic [FW-1:0]    frac_o
);
    logic [ES+FW-1:0] shifted;
    logic [CW-1:0]    amount;

    always_comb begin
        amount  = run_i - 1'b1;
        shifted = tail_i << amount;
        exp_o   = shifted[ES+FW-1 -: ES];
        frac_o  = shifted[FW-1:0];
    end
endmodule

// File: rtl/posit_decoder.sv
module posit_decoder
    import posit_dec_pkg::*;
#(
    parameter int N  = 16,
    parameter int ES = 2,
    parameter int SW = scale_width(N, ES),
    parameter int FW = frac_width(N, ES)
) (
    input  logic [N-1:0]         pw_i,
    output logic                 neg_o,
    output logic                 is_zero_o,
    output logic                 is_nar_o,
    output logic signed [SW-1:0] scale_o,
    output logic [FW:0]          signif_o
);
    localparam int W  = N - 1;
    localparam int CW = $clog2(W + 1);
    localparam logic signed [SW-1:0] ONE = SW'(1);

    logic [W-1:0]          body;
    logic                  lead;
    logic [CW-1:0]         run_len;
    logic [ES-1:0]         exp_bits;
    logic [FW-1:0]         frac_bits;
    logic signed [SW-1:0]  run_ext;
    logic signed [SW-1:0]  regime;
    logic                  special;

    posit_abs #(.N(N)) u_abs (
        .word_i (pw_i),
        .body_o (body)
    );

    posit_run_count #(.W(W), .CW(CW)) u_run (
        .bits_i (body),
        .lead_o (lead),
        .run_o  (run_len)
    );

    posit_field_align #(.ES(ES), .FW(FW), .CW(CW)) u_align (
        .tail_i (body[W-3:0]),
        .run_i  (run_len),
        .exp_o  (exp_bits),
        .frac_o (frac_bits)
    );

    always_comb begin
        is_zero_o = (pw_i == '0);
        is_nar_o  = (pw_i == {1'b1, {(N-1){1'b0}}});
        special   = is_zero_o | is_nar_o;
        run_ext   = $signed(SW'(run_len));
        regime    = lead ? (run_ext - ONE) : (-run_ext);
        if (special) begin
            neg_o    = 1'b0;
            scale_o  = '0;
            signif_o = '0;
        end else begin
            neg_o    = pw_i[N-1];
            scale_o  = (regime <<< ES) + $signed(SW'(exp_bits));
            signif_o = {1'b1, frac_bits};
        end
    end
endmodule

// File: rtl/posit_decoder_chk.sv
module posit_decoder_chk #(
    parameter int N  = 16,
    parameter int ES = 2,
    parameter int SW = 8,
    parameter int FW = 11
) (
    input logic [N-1:0]         pw_i,
    input logic                 neg_o,
    input logic                 is_zero_o,
    input logic                 is_nar_o,
    input logic signed [SW-1:0] scale_o,
    input logic [FW:0]          signif_o
);
    localparam int SMAX = ((N - 2) << ES) + (1 << ES) - 1;
    localparam int SMIN = -((N - 1) << ES);

    always_comb begin
        if (!$isunknown(pw_i)) begin
            p_flags_excl_r2: assert (!(is_zero_o && is_nar_o));
            p_special_quiet_r1: assert (!(is_zero_o || is_nar_o) ||
                (signif_o == '0 && scale_o == '0 && !neg_o));
            p_hidden_bit_r6: assert ((is_zero_o || is_nar_o) || signif_o[FW]);
            p_scale_range_r4: assert (int'(scale_o) <= SMAX && int'(scale_o) >= SMIN);
            p_sign_follow_r3: assert ((is_zero_o || is_nar_o) || (neg_o == pw_i[N-1]));
        end
    end
endmodule

bind posit_decoder posit_decoder_chk #(.N(N), .ES(ES), .SW(SW), .FW(FW)) u_chk (.*);

// File: tb/posit_decoder_tb.sv
module posit_decoder_tb;
    localparam int N  = 16;
    localparam int ES = 2;
    localparam int SW = posit_dec_pkg::scale_width(N, ES);
    localparam int FW = posit_dec_pkg::frac_width(N, ES);

    typedef struct {
        logic [N-1:0] w;
        logic         s;
        logic         z;
        logic         n;
        int           sc;
        logic [FW:0]  sig;
        string        tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pw = '0;
    logic neg, zf, nf;
    logic signed [SW-1:0] scale;
    logic [FW:0] sig;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t q[$];

    always #10 clk = ~clk;

    posit_decoder #(.N(N), .ES(ES)) u_dut (
        .pw_i      (pw),
        .neg_o     (neg),
        .is_zero_o (zf),
        .is_nar_o  (nf),
        .scale_o   (scale),
        .signif_o  (sig)
    );

    function automatic item_t walk(logic [N-1:0] w, string tag);
        item_t it;
        logic [N-1:0] v;
        logic ld;
        int i, k, e, fr;
        it.w = w; it.tag = tag;
        it.z = (w == '0);
        it.n = (w == {1'b1, {(N-1){1'b0}}});
        it.s = 1'b0; it.sc = 0; it.sig = '0;
        if (it.z || it.n) return it;
        it.s = w[N-1];
        v = w[N-1] ? (~w + 1'b1) : w;
        i = N - 2; ld = v[i]; k = 0;
        while (i >= 0 && v[i] == ld) begin k++; i--; end
        i--;
        e = 0;
        for (int j = 0; j < ES; j++) begin
            e = e * 2 + ((i >= 0) ? int'(v[i]) : 0); i--;
        end
        fr = 0;
        for (int j = 0; j < FW; j++) begin
            fr = fr * 2 + ((i >= 0) ? int'(v[i]) : 0); i--;
        end
        it.sc = (ld ? k - 1 : -k) * (1 << ES) + e;
        it.sig = {1'b1, FW'(fr)};
        return it;
    endfunction

    task automatic drive(item_t it);
        @(posedge clk);
        #1 pw = it.w;
        q.push_back(it);
    endtask

    task automatic known(logic [N-1:0] w, logic s, logic z, logic n, int sc,
                         logic [FW:0] sg, string tag);
        item_t it;
        it.w = w; it.s = s; it.z = z; it.n = n; it.sc = sc; it.sig = sg; it.tag = tag;
        drive(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            int got;
            it = q.pop_front();
            got = int'(scale);
            checks++;
            if (neg !== it.s || zf !== it.z || nf !== it.n || got != it.sc || sig !== it.sig) begin
                errors++;
                $display("FAIL %s word=%h actual s=%b z=%b n=%b sc=%0d sig=%h expected s=%b z=%b n=%b sc=%0d sig=%h",
                         it.tag, it.w, neg, zf, nf, got, sig, it.s, it.z, it.n, it.sc, it.sig);
            end
        end
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        known(16'h0000, 0, 1, 0, 0, 12'h000, "R1 reset zero");
        known(16'h8000, 0, 0, 1, 0, 12'h000, "R2 nar");
        known(16'h4000, 0, 0, 0, 0, 12'h800, "R4 one");
        known(16'hC000, 1, 0, 0, 0, 12'h800, "R3 minus one");
        known(16'h8001, 1, 0, 0, 56, 12'h800, "R3 negated max");
        known(16'h3800, 0, 0, 0, -1, 12'h800, "R4 half");
        known(16'h7FFF, 0, 0, 0, 56, 12'h800, "R4 max");
        known(16'h0001, 0, 0, 0, -56, 12'h800, "R4 min");
        known(16'h0003, 0, 0, 0, -50, 12'h800, "R5 one exp bit");
        known(16'h0002, 0, 0, 0, -52, 12'h800, "R5 one exp bit zero");
        known(16'h5000, 0, 0, 0, 2, 12'h800, "R5 full exp");
        known(16'h4001, 0, 0, 0, 0, 12'h801, "R6 low frac bit");
        known(16'h4400, 0, 0, 0, 0, 12'hC00, "R6 high frac bit");
        for (int w = 0; w < (1 << N); w++) begin
            drive(walk(N'(w), "R7 sweep"));
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule